// File: doc/BRIEF.md
# Multi-mode PWM fan driver

The block drives a set of pulse-width-modulated fan outputs, four by default. Each channel owns two byte registers: a control byte, which carries an output-enable bit and a three-bit mode code, and a duty byte. A host writes and reads these registers through a small banked bus. An 8-bit bank number picks the channel, and a short offset picks the register within that bank.

All channels share one free-running period counter. This counter advances only on a clock-enable tick, so one period lasts 256 ticks. A channel's output is high while the counter is below that channel's active duty. The active duty is loaded only at the boundary between periods, so a write made in the middle of a period never cuts a pulse short.

The mode code chooses how the output is produced:
- Manual: the output uses the duty register.
- Automatic: the duty comes from an external per-channel duty input. The temperature-to-duty curve lives outside this block.
- Forced off: the output is held low.
- Forced full on: the output is held high.

Top module: `fanpwm_top`

## Requirements
- R1: After reset every control and duty register reads 0, the period counter is at 0 and every PWM output is low.
- R2: Bank number 0x10 + 2·n addresses channel n (n = 0..NCH-1). In that bank, offset 0x10 is the control byte and offset 0x12 is the duty byte. Both read back as written. A write to any other bank or offset changes no register and no output. Reads from unmapped locations return 0.
- R3: While control bit 0 (enable) is 0, the channel output is low whatever the mode and duty.
- R4: With enable set and mode 0 (manual, control bits 6:4), the output is high for exactly duty-byte ticks of each 256-tick period. Duty 0xFF gives 255 high ticks and duty 0 gives none.
- R5: With mode 1 (automatic), the high time per period equals the channel's external duty input. The duty register is not used.
- R6: Mode 2 holds the output low and mode 7 holds it high, both regardless of the duty byte.
- R7: Mode codes 3 to 6 drive the output low, like mode 2, and the control byte still reads back exactly as written.
- R8: The duty in use, whether the register or the external input, is captured only when the counter wraps from 255 to 0. A change in the middle of a period has no effect until the next period.
- R9: The period counter advances by one on each cycle with the tick input high and holds when the tick is low. In the same cycle the counter holds the value 0..255 and the output is high exactly when the counter is below the active duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Clock enable for the period counter |
| bus_wr_i | input | 1 | Register write strobe |
| bus_bank_i | input | 8 | Bank number selecting the channel |
| bus_addr_i | input | 5 | Register offset inside the bank |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, 0 if unmapped |
| auto_duty_i | input | NCH*8 | External duty per channel, channel n in bits 8n+7:8n |
| pwm_o | output | NCH | PWM outputs, one bit per channel |

## Verification
The bench targets the duty extremes: 0 must give no pulse, 0xFF must give 255 of 256 ticks, and full-on must give all 256. An off-by-one compare would shift each of these by one tick. It writes a new duty and moves the external duty in the middle of a period, then samples just past the old edge. A design that loads the duty at once would show the new level a period early. It also covers the undefined mode codes, a cleared enable bit, and writes to a neighbouring bank or offset. A design that decodes loosely would switch a channel it was never told to touch. Finally, it stalls the tick just before a falling edge to show that the output freezes along with the counter.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
    localparam int DUTY_W  = 8;
    localparam int MODE_LO = 4;
    localparam int MODE_HI = 6;
    localparam int EN_BIT  = 0;

    localparam logic [2:0] MODE_MANUAL = 3'd0;
    localparam logic [2:0] MODE_AUTO   = 3'd1;
    localparam logic [2:0] MODE_OFF    = 3'd2;
    localparam logic [2:0] MODE_FULL   = 3'd7;

    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/fanpwm_period.sv
module fanpwm_period #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == CNT_MAX);

    // R9: one step per tick
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == $past(cnt_q) + 1'b1);
    // R9: no tick, no movement
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/fanpwm_regs.sv
module fanpwm_regs #(
    parameter int         NCH       = 4,
    parameter int         AW        = 5,
    parameter logic [7:0] BANK_BASE = 8'h10,
    parameter int         BANK_STEP = 2,
    parameter logic [AW-1:0] OFF_CTRL = 5'h10,
    parameter logic [AW-1:0] OFF_DUTY = 5'h12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [7:0]         bank_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic [NCH-1:0][7:0] ctrl_o,
    output logic [NCH-1:0][7:0] duty_o
);
    typedef struct packed {
        logic [NCH-1:0][7:0] ctrl;
        logic [NCH-1:0][7:0] duty;
    } regs_t;

    regs_t st_d, st_q;
    logic  any_hit;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (bank_i == 8'(BANK_BASE + BANK_STEP * i)) begin
                if (addr_i == OFF_CTRL) begin
                    rdata_o = st_q.ctrl[i];
                    any_hit = 1'b1;
                    if (wr_i) st_d.ctrl[i] = wdata_i;
                end else if (addr_i == OFF_DUTY) begin
                    rdata_o = st_q.duty[i];
                    any_hit = 1'b1;
                    if (wr_i) st_d.duty[i] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign duty_o = st_q.duty;

    // R2: a write that decodes to nothing leaves every register alone
    p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !any_hit) |=> ($stable(st_q.ctrl) && $stable(st_q.duty)));
endmodule

// File: rtl/fanpwm_chan.sv
module fanpwm_chan
    import fanpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic [7:0] ctrl_i,
    input  duty_t duty_i,
    input  duty_t auto_i,
    input  duty_t cnt_i,
    input  logic  wrap_i,
    output logic  pwm_o
);
    duty_t      act_d, act_q;
    logic [2:0] mode;
    logic       en;

    assign mode = ctrl_i[MODE_HI:MODE_LO];
    assign en   = ctrl_i[EN_BIT];

    always_comb begin
        act_d = act_q;
        if (wrap_i) act_d = (mode == MODE_AUTO) ? auto_i : duty_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    always_comb begin
        pwm_o = 1'b0;
        if (en) begin
            unique case (mode)
                MODE_MANUAL, MODE_AUTO: pwm_o = (cnt_i < act_q);
                MODE_FULL:              pwm_o = 1'b1;
                default:                pwm_o = 1'b0;
            endcase
        end
    end

    // R8: the duty in use moves only at the period boundary
    p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(act_q));
endmodule

// File: rtl/fanpwm_top.sv
module fanpwm_top
    import fanpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_bank_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [NCH*8-1:0]  auto_duty_i,
    output logic [NCH-1:0]    pwm_o
);
    logic [NCH-1:0][7:0] ctrl, duty;
    duty_t               cnt;
    logic                wrap;

    fanpwm_period #(.W(DUTY_W)) u_period (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cnt_o(cnt), .wrap_o(wrap)
    );

    fanpwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .bank_i(bus_bank_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
        .ctrl_o(ctrl), .duty_o(duty)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        fanpwm_chan u_chan (
            .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl[g]), .duty_i(duty[g]),
            .auto_i(auto_duty_i[g*8 +: 8]), .cnt_i(cnt), .wrap_i(wrap),
            .pwm_o(pwm_o[g])
        );

        // R3: a disabled channel stays low across cycles
        p_disabled_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[g][EN_BIT] |-> !pwm_o[g]);
        // R6: forced off gives a low output
        p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[g][MODE_HI:MODE_LO] == MODE_OFF) |-> !pwm_o[g]);
    end
endmodule

// File: tb/test_fanpwm_top.sv
module test_fanpwm_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic wr = 1'b0;
    logic [7:0] bank = '0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NCH*8-1:0] auto_duty = '0;
    logic [NCH-1:0] pwm;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] bcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fanpwm_top i_fanpwm_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr),
        .bus_bank_i(bank), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .auto_duty_i(auto_duty), .pwm_o(pwm)
    );

    // bench model of the period position (R9)
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (tick) bcnt <= bcnt + 8'd1;
    end

    // vector: {ch, ctrl, duty, auto, expected high ticks}
    localparam logic [34:0] VECS [0:9] = '{
        {2'd0, 8'h01, 8'h40, 8'h00, 9'd64},   // R4 manual
        {2'd1, 8'h01, 8'hFF, 8'h00, 9'd255},  // R4 max duty
        {2'd2, 8'h01, 8'h00, 8'h00, 9'd0},    // R4 zero duty
        {2'd3, 8'h11, 8'h10, 8'h90, 9'd144},  // R5 automatic
        {2'd0, 8'h21, 8'h80, 8'h00, 9'd0},    // R6 off
        {2'd1, 8'h71, 8'h00, 8'h00, 9'd256},  // R6 full on
        {2'd2, 8'h31, 8'h80, 8'h00, 9'd0},    // R7 undefined code
        {2'd3, 8'h61, 8'hC0, 8'hC0, 9'd0},    // R7 undefined code
        {2'd0, 8'h70, 8'h80, 8'h00, 9'd0},    // R3 enable cleared
        {2'd3, 8'h01, 8'h01, 8'h00, 9'd1}     // R4 duty 1
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] b, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bank = b; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] b, input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bank = b; addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        do @(negedge clk); while (bcnt != v);
    endtask

    task automatic measure(input int ch, output int highs);
        highs = 0;
        wait_cnt(8'd0);
        for (int k = 0; k < 256; k++) begin
            if (pwm[ch]) highs++;
            if (k != 255) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check("R1 pwm after reset", int'(pwm), 0);
        bus_read(8'h10, 5'h10, rd); check("R1 ctrl0 reset", rd, 0);
        bus_read(8'h16, 5'h12, rd); check("R1 duty3 reset", rd, 0);

        for (int v = 0; v < 10; v++) begin
            automatic int ch = int'(VECS[v][34:33]);
            auto_duty[ch*8 +: 8] = VECS[v][16:9];
            bus_write(8'(8'h10 + 2*ch), 5'h10, VECS[v][32:25]);
            bus_write(8'(8'h10 + 2*ch), 5'h12, VECS[v][24:17]);
            bus_read(8'(8'h10 + 2*ch), 5'h10, rd);
            check("R2/R7 ctrl readback", rd, int'(VECS[v][32:25]));
            bus_read(8'(8'h10 + 2*ch), 5'h12, rd);
            check("R2 duty readback", rd, int'(VECS[v][24:17]));
            measure(ch, h);
            check("R3-R7 vector high ticks", h, int'(VECS[v][8:0]));
        end

        // R2 stray writes: ch0 manual duty 0, then full-on writes that miss
        bus_write(8'h10, 5'h10, 8'h01);
        bus_write(8'h10, 5'h12, 8'h00);
        bus_write(8'h11, 5'h10, 8'h71);
        bus_write(8'h10, 5'h11, 8'h71);
        bus_write(8'h18, 5'h10, 8'h71);
        bus_read(8'h10, 5'h10, rd); check("R2 ctrl0 untouched", rd, 8'h01);
        bus_read(8'h11, 5'h10, rd); check("R2 unmapped read", rd, 0);
        measure(0, h); check("R2 ch0 output untouched", h, 0);

        // R8 manual duty change mid-period
        bus_write(8'h12, 5'h10, 8'h01);
        bus_write(8'h12, 5'h12, 8'h80);
        measure(1, h); check("R8 ch1 base duty", h, 128);
        wait_cnt(8'h90);
        bus_write(8'h12, 5'h12, 8'hFF);
        wait_cnt(8'hA0); check("R8 old duty kept", int'(pwm[1]), 0);
        wait_cnt(8'hA0); check("R8 new duty next period", int'(pwm[1]), 1);

        // R8 automatic input change mid-period
        bus_write(8'h14, 5'h10, 8'h11);
        auto_duty[2*8 +: 8] = 8'h20;
        measure(2, h); check("R5 ch2 auto duty", h, 32);
        wait_cnt(8'h10);
        auto_duty[2*8 +: 8] = 8'hF0;
        wait_cnt(8'h30); check("R8 auto old sample kept", int'(pwm[2]), 0);
        wait_cnt(8'h30); check("R8 auto new sample", int'(pwm[2]), 1);

        // R9 tick stall just before the falling edge of ch1 (duty 0x80)
        bus_write(8'h12, 5'h12, 8'h80);
        measure(1, h);
        wait_cnt(8'h7E);
        tick = 1'b0;
        h = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (pwm[1]) h++;
        end
        check("R9 output frozen while tick low", h, 300);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 resumes and falls", int'(pwm[1]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule